// File: doc/BRIEF.md
# MSI Event Queue Controller

This block sits behind the inbound side of a PCIe root complex. It takes message-signalled interrupt writes and sorts them into a small set of interrupt groups. Each inbound write carries an address offset inside the message window and a data word. The offset picks the target group. The low bits of the data word are the vector number, and they are appended to that group's circular event queue. The hardware owns the tail pointer of each queue and advances it. A group's interrupt line stays high while its queue holds unserviced events and its enables allow it.

Software works through a narrow register port. It reads the tail to find new work and reads queued vectors at any index. It writes the head back to retire entries, and it programs each group's control bits. A build option chooses the address stride between groups: either 4 bytes, with all groups packed in one region, or 4 KiB, with one region per group. A second build option adds a legacy per-group interrupt mask.

Top module: `msi_evq_ctrl`

## Requirements
- R1: After reset every head, tail, control register, overflow flag and legacy mask bit reads 0, and every interrupt output is low.
- R2: With the 4-byte stride, the group index is `msg_addr >> 2`. A message whose group index is not below NUM_GRP leaves every tail and every overflow flag unchanged.
- R3: With the 4 KiB stride, the group index is `msg_addr >> 12`. Offset 8 therefore lands in group 0, and offset 0x2000 lands in group 2.
- R4: An accepted message stores `msg_data[5:0]` at the group's tail index and advances the tail by one. Register kind 5 (`reg_kind`=5) returns the stored vector at `reg_idx` of group `reg_grp`.
- R5: Head and tail are 6 bits wide and wrap from 63 to 0. The number of pending events is (tail − head) mod 64. The head is kind 0 (read/write) and the tail is kind 1 (read-only).
- R6: A message to a group whose queue enable is clear, or whose queue is full (tail+1 = head mod 64, so 63 entries at most), is dropped. The drop sets that group's sticky overflow flag, read at bit 0 of kind 3, and touches no other group.
- R7: A group's interrupt is high exactly when head ≠ tail and both control bit 1 (interrupt per event) and control bit 11 (interrupt enable) are set. It drops in the cycle after software writes a head equal to the tail.
- R8: With the legacy mask built in, kind 4 holds one bit per group (bit g for group g). A group's interrupt is also gated by its mask bit.
- R9: A message and a head write that reach the same group in the same cycle both take effect. The full test uses the head value from before the write.
- R10: The control register is kind 2. Queue enable is bit 0, interrupt per event is bit 1, and interrupt enable is bit 11. All other bits are not stored and read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | An inbound message write is present this cycle |
| msg_addr | input | ADDR_W | Offset of the write inside the message window |
| msg_data | input | DATA_W | Message data word; the low VEC_W bits are kept |
| reg_wr | input | 1 | Register write strobe |
| reg_kind | input | 3 | Register selector: 0 head, 1 tail, 2 control, 3 overflow, 4 legacy mask, 5 queue entry |
| reg_grp | input | GRP_W | Group addressed by the register access |
| reg_idx | input | PTR_W | Entry index for kind 5 reads |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational register read data |
| irq_o | output | NUM_GRP | One interrupt line per group |

## Verification
The bench fills one queue across the pointer wrap until it is full. An off-by-one full test would either overwrite the oldest unread vector or refuse the 63rd entry. The 64th message must be dropped and must raise the overflow flag only for that group. A message and a head write are sent to the same group in one cycle, which catches a design that lets either update overwrite the other. Out-of-range offsets and the 4 KiB stride are used to expose a decoder that aliases addresses into the wrong group. Interrupts are checked with each enable bit cleared in turn and after the head is retired to the tail, so a line that sticks or fires too early shows up.

// File: rtl/msi_evq_pkg.sv
`timescale 1ns/1ps
package msi_evq_pkg;
   localparam int REG_W    = 16;
   localparam int CTL_QEN  = 0;
   localparam int CTL_EACH = 1;
   localparam int CTL_IEN  = 11;

   typedef enum logic [2:0] {
      RK_HEAD  = 3'd0,
      RK_TAIL  = 3'd1,
      RK_CTRL  = 3'd2,
      RK_OVF   = 3'd3,
      RK_MASK  = 3'd4,
      RK_ENTRY = 3'd5
   } reg_kind_e;

   typedef struct packed {
      logic ien;
      logic each;
      logic qen;
   } grp_ctl_t;
endpackage

// File: rtl/msi_grp_decode.sv
`timescale 1ns/1ps
module msi_grp_decode #(
   parameter int NUM_GRP      = 6,
   parameter int ADDR_W       = 16,
   parameter bit MULTI_REGION = 1'b0
) (
   input  logic               msg_valid,
   input  logic [ADDR_W-1:0]  msg_addr,
   output logic [NUM_GRP-1:0] hit_oh
);
   localparam int SHIFT = MULTI_REGION ? 12 : 2;

   logic [ADDR_W-1:0] slot;
   logic              unused_lo;

   if (ADDR_W <= SHIFT + 1) begin : g_bad_addr
      $error("msi_grp_decode: ADDR_W too small for the chosen stride");
   end

   if (MULTI_REGION) begin : g_region_stride
      assign slot = msg_addr >> 12;
   end else begin : g_word_stride
      assign slot = msg_addr >> 2;
   end

   assign unused_lo = ^msg_addr[SHIFT-1:0];

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_hit
      assign hit_oh[g] = msg_valid && (slot == ADDR_W'(g));
   end
endmodule

// File: rtl/msi_evq_group.sv
`timescale 1ns/1ps
module msi_evq_group
   import msi_evq_pkg::*;
#(
   parameter int PTR_W = 6,
   parameter int VEC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [VEC_W-1:0] push_vec,
   input  logic             head_wr,
   input  logic [PTR_W-1:0] head_wdata,
   input  logic             ctl_wr,
   input  grp_ctl_t         ctl_wdata,
   input  logic [PTR_W-1:0] rd_idx,
   output logic [PTR_W-1:0] head_q,
   output logic [PTR_W-1:0] tail_q,
   output grp_ctl_t         ctl_q,
   output logic             ovf_q,
   output logic [VEC_W-1:0] rd_vec,
   output logic             irq_req
);
   localparam int DEPTH = 1 << PTR_W;

   logic [VEC_W-1:0] slots [DEPTH];
   logic             full;
   logic             accept;

   assign full   = PTR_W'(tail_q + 1'b1) == head_q;
   assign accept = push && ctl_q.qen && !full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         ctl_q  <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (accept)          tail_q <= tail_q + 1'b1;
         if (head_wr)         head_q <= head_wdata;
         if (ctl_wr)          ctl_q  <= ctl_wdata;
         if (push && !accept) ovf_q  <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) slots[tail_q] <= push_vec;
   end

   assign rd_vec  = slots[rd_idx];
   assign irq_req = (head_q != tail_q) && ctl_q.ien && ctl_q.each;
endmodule

// File: rtl/msi_evq_rdmux.sv
`timescale 1ns/1ps
module msi_evq_rdmux
   import msi_evq_pkg::*;
#(
   parameter int NUM_GRP = 6,
   parameter int GRP_W   = 3,
   parameter int PTR_W   = 6,
   parameter int VEC_W   = 6
) (
   input  logic [2:0]                    kind,
   input  logic [GRP_W-1:0]              grp,
   input  logic [NUM_GRP-1:0][PTR_W-1:0] head_vec,
   input  logic [NUM_GRP-1:0][PTR_W-1:0] tail_vec,
   input  grp_ctl_t [NUM_GRP-1:0]        ctl_vec,
   input  logic [NUM_GRP-1:0]            ovf_vec,
   input  logic [NUM_GRP-1:0]            mask_vec,
   input  logic [NUM_GRP-1:0][VEC_W-1:0] rd_vec,
   output logic [REG_W-1:0]              rdata
);
   logic             grp_ok;
   logic [GRP_W-1:0] sel;

   assign grp_ok = 32'(grp) < NUM_GRP;
   assign sel    = grp_ok ? grp : '0;

   always_comb begin
      rdata = '0;
      case (reg_kind_e'(kind))
         RK_HEAD:  if (grp_ok) rdata = REG_W'(head_vec[sel]);
         RK_TAIL:  if (grp_ok) rdata = REG_W'(tail_vec[sel]);
         RK_CTRL:  if (grp_ok) begin
            rdata[CTL_QEN]  = ctl_vec[sel].qen;
            rdata[CTL_EACH] = ctl_vec[sel].each;
            rdata[CTL_IEN]  = ctl_vec[sel].ien;
         end
         RK_OVF:   if (grp_ok) rdata[0] = ovf_vec[sel];
         RK_MASK:  rdata = REG_W'(mask_vec);
         RK_ENTRY: if (grp_ok) rdata = REG_W'(rd_vec[sel]);
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/msi_evq_ctrl.sv
`timescale 1ns/1ps
module msi_evq_ctrl
   import msi_evq_pkg::*;
#(
   parameter int NUM_GRP      = 6,
   parameter int QDEPTH       = 64,
   parameter int VEC_W        = 6,
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 32,
   parameter bit MULTI_REGION = 1'b0,
   parameter bit LEGACY_INTEN = 1'b0,
   localparam int PTR_W = $clog2(QDEPTH),
   localparam int GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               msg_valid,
   input  logic [ADDR_W-1:0]  msg_addr,
   input  logic [DATA_W-1:0]  msg_data,
   input  logic               reg_wr,
   input  logic [2:0]         reg_kind,
   input  logic [GRP_W-1:0]   reg_grp,
   input  logic [PTR_W-1:0]   reg_idx,
   input  logic [15:0]        reg_wdata,
   output logic [15:0]        reg_rdata,
   output logic [NUM_GRP-1:0] irq_o
);
   if (QDEPTH != (1 << PTR_W) || QDEPTH < 2) begin : g_bad_depth
      $error("msi_evq_ctrl: QDEPTH must be a power of two of at least 2");
   end
   if (NUM_GRP < 1 || NUM_GRP > REG_W) begin : g_bad_grp
      $error("msi_evq_ctrl: NUM_GRP must lie between 1 and 16");
   end
   if (VEC_W > DATA_W || VEC_W > REG_W) begin : g_bad_vec
      $error("msi_evq_ctrl: VEC_W wider than data or register word");
   end

   logic [NUM_GRP-1:0]            hit_oh;
   logic [NUM_GRP-1:0]            head_wr;
   logic [NUM_GRP-1:0]            ctl_wr;
   logic [NUM_GRP-1:0][PTR_W-1:0] head_vec;
   logic [NUM_GRP-1:0][PTR_W-1:0] tail_vec;
   grp_ctl_t [NUM_GRP-1:0]        ctl_vec;
   logic [NUM_GRP-1:0]            ovf_vec;
   logic [NUM_GRP-1:0]            irq_req;
   logic [NUM_GRP-1:0][VEC_W-1:0] rd_vec;
   logic [NUM_GRP-1:0]            mask_vec;
   logic [NUM_GRP-1:0]            gate_vec;
   grp_ctl_t                      ctl_wd;
   logic                          unused_bits;

   assign ctl_wd      = '{ien: reg_wdata[CTL_IEN], each: reg_wdata[CTL_EACH],
                          qen: reg_wdata[CTL_QEN]};
   assign unused_bits = ^{msg_data, reg_wdata};

   msi_grp_decode #(
      .NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W), .MULTI_REGION(MULTI_REGION)
   ) u_decode (
      .msg_valid(msg_valid), .msg_addr(msg_addr), .hit_oh(hit_oh)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      assign head_wr[g] = reg_wr && (reg_kind == RK_HEAD) && (reg_grp == GRP_W'(g));
      assign ctl_wr[g]  = reg_wr && (reg_kind == RK_CTRL) && (reg_grp == GRP_W'(g));

      msi_evq_group #(.PTR_W(PTR_W), .VEC_W(VEC_W)) u_q (
         .clk(clk), .rst_n(rst_n),
         .push(hit_oh[g]), .push_vec(msg_data[VEC_W-1:0]),
         .head_wr(head_wr[g]), .head_wdata(reg_wdata[PTR_W-1:0]),
         .ctl_wr(ctl_wr[g]), .ctl_wdata(ctl_wd),
         .rd_idx(reg_idx),
         .head_q(head_vec[g]), .tail_q(tail_vec[g]), .ctl_q(ctl_vec[g]),
         .ovf_q(ovf_vec[g]), .rd_vec(rd_vec[g]), .irq_req(irq_req[g])
      );
   end

   if (LEGACY_INTEN) begin : g_legacy_mask
      always_ff @(posedge clk) begin
         if (!rst_n)
            mask_vec <= '0;
         else if (reg_wr && reg_kind == RK_MASK)
            mask_vec <= reg_wdata[NUM_GRP-1:0];
      end
      assign gate_vec = mask_vec;
   end else begin : g_no_mask
      assign mask_vec = '0;
      assign gate_vec = '1;
   end

   assign irq_o = irq_req & gate_vec;

   msi_evq_rdmux #(
      .NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .PTR_W(PTR_W), .VEC_W(VEC_W)
   ) u_rdmux (
      .kind(reg_kind), .grp(reg_grp),
      .head_vec(head_vec), .tail_vec(tail_vec), .ctl_vec(ctl_vec),
      .ovf_vec(ovf_vec), .mask_vec(mask_vec), .rd_vec(rd_vec),
      .rdata(reg_rdata)
   );
endmodule

// File: rtl/msi_evq_ctrl_chk.sv
`timescale 1ns/1ps
module msi_evq_ctrl_chk #(
   parameter int NUM_GRP      = 6,
   parameter int PTR_W        = 6,
   parameter int ADDR_W       = 16,
   parameter bit MULTI_REGION = 1'b0
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            msg_valid,
   input logic [ADDR_W-1:0]               msg_addr,
   input logic [NUM_GRP-1:0][PTR_W-1:0]   head_vec,
   input logic [NUM_GRP-1:0][PTR_W-1:0]   tail_vec,
   input logic [NUM_GRP-1:0]              ovf_vec,
   input logic [NUM_GRP-1:0]              irq_o,
   input logic [NUM_GRP-1:0]              gate_vec
);
   logic [ADDR_W-1:0] slot;
   assign slot = MULTI_REGION ? (msg_addr >> 12) : (msg_addr >> 2);

   // R2
   stray_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && slot >= ADDR_W'(NUM_GRP)) |=> ($stable(tail_vec) && $stable(ovf_vec)));

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
      // R5
      tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tail_vec[g] != $past(tail_vec[g])) |->
            (tail_vec[g] == PTR_W'($past(tail_vec[g]) + 1'b1)));

      // R6
      full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (PTR_W'($past(tail_vec[g]) + 1'b1) == $past(head_vec[g])) |->
            (tail_vec[g] == $past(tail_vec[g])));

      // R6
      ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(ovf_vec[g]) |-> ovf_vec[g]);

      // R7
      irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[g] |-> (head_vec[g] != tail_vec[g]));

      // R8
      legacy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[g] |-> gate_vec[g]);
   end
endmodule

bind msi_evq_ctrl msi_evq_ctrl_chk #(
   .NUM_GRP(NUM_GRP), .PTR_W(PTR_W), .ADDR_W(ADDR_W), .MULTI_REGION(MULTI_REGION)
) u_chk (
   .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_addr(msg_addr),
   .head_vec(head_vec), .tail_vec(tail_vec), .ovf_vec(ovf_vec),
   .irq_o(irq_o), .gate_vec(gate_vec)
);

// File: tb/msi_evq_ctrl_bench.sv
`timescale 1ns/1ps
module msi_evq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mv = '0;
   logic [1:0]  rw = '0;
   logic [15:0] maddr = '0;
   logic [31:0] mdata = '0;
   logic [2:0]  rkind = '0;
   logic [2:0]  rgrp = '0;
   logic [5:0]  ridx = '0;
   logic [15:0] rwd = '0;
   logic [15:0] rd_a, rd_b;
   logic [5:0]  irq_a;
   logic [3:0]  irq_b;

   int checks = 0;
   int errors = 0;

   int mh [6];
   int mt [6];
   bit men[6];
   int sb [6][$];

   always #2.5 clk = ~clk;

   msi_evq_ctrl u_msi_evq_ctrl (
      .clk(clk), .rst_n(rst_n), .msg_valid(mv[0]), .msg_addr(maddr),
      .msg_data(mdata), .reg_wr(rw[0]), .reg_kind(rkind), .reg_grp(rgrp),
      .reg_idx(ridx), .reg_wdata(rwd), .reg_rdata(rd_a), .irq_o(irq_a)
   );

   msi_evq_ctrl #(.NUM_GRP(4), .MULTI_REGION(1'b1), .LEGACY_INTEN(1'b1)) u_msi_evq_ctrl_mr (
      .clk(clk), .rst_n(rst_n), .msg_valid(mv[1]), .msg_addr(maddr),
      .msg_data(mdata), .reg_wr(rw[1]), .reg_kind(rkind), .reg_grp(rgrp[1:0]),
      .reg_idx(ridx), .reg_wdata(rwd), .reg_rdata(rd_b), .irq_o(irq_b)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive_msg(int inst, int addr, logic [31:0] d);
      @(negedge clk);
      mv[inst] = 1'b1; maddr = 16'(addr); mdata = d;
      @(negedge clk);
      mv[inst] = 1'b0;
   endtask

   task automatic wreg(int inst, int kind, int grp, int val);
      @(negedge clk);
      rw[inst] = 1'b1; rkind = 3'(kind); rgrp = 3'(grp); rwd = 16'(val);
      @(negedge clk);
      rw[inst] = 1'b0;
   endtask

   task automatic rreg(int inst, int kind, int grp, int idx, output int v);
      @(negedge clk);
      rkind = 3'(kind); rgrp = 3'(grp); ridx = 6'(idx);
      #1;
      v = (inst == 0) ? int'(rd_a) : int'(rd_b);
   endtask

   // driver: predicts acceptance and pushes the expected vector
   task automatic send_a(int addr, logic [31:0] d);
      int g = addr / 4;
      if (g < 6 && men[g] && ((mt[g] + 1) % 64) != mh[g]) begin
         sb[g].push_back(int'(d[5:0]));
         mt[g] = (mt[g] + 1) % 64;
      end
      drive_msg(0, addr, d);
   endtask

   // monitor: pops expected vectors and compares against the queue contents
   task automatic drain_a(int g);
      int t, h, v, n;
      rreg(0, 0, g, 0, h);
      chk("R5 head", h, mh[g]);
      rreg(0, 1, g, 0, t);
      chk("R5 tail", t, mt[g]);
      n = (t - h + 64) % 64;
      chk("R5 pending count", n, sb[g].size());
      for (int i = 0; i < n; i++) begin
         rreg(0, 5, g, (h + i) % 64, v);
         if (sb[g].size() > 0) chk("R4 entry", v, sb[g].pop_front());
      end
      wreg(0, 0, g, t);
      mh[g] = t;
      chk("R7 irq after retire", int'(irq_a[g]), 0);
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1: actual hang expected finish");
      summary();
      $finish;
   end

   initial begin
      int v, t0;
      int tails[6];
      for (int g = 0; g < 6; g++) begin mh[g] = 0; mt[g] = 0; men[g] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      foreach (tails[g]) begin
         if (g == 0 || g == 5) begin
            rreg(0, 0, g, 0, v); chk("R1 head", v, 0);
            rreg(0, 1, g, 0, v); chk("R1 tail", v, 0);
            rreg(0, 2, g, 0, v); chk("R1 ctrl", v, 0);
            rreg(0, 3, g, 0, v); chk("R1 ovf", v, 0);
         end
      end
      rreg(1, 4, 0, 0, v); chk("R1 mask", v, 0);
      chk("R1 irq a", int'(irq_a), 0);
      chk("R1 irq b", int'(irq_b), 0);

      // R10 control field layout
      wreg(0, 2, 0, 16'hFFFF);
      rreg(0, 2, 0, 0, v); chk("R10 ctrl readback", v, 16'h0803);
      for (int g = 0; g < 6; g++) begin wreg(0, 2, g, 16'h0803); men[g] = 1; end

      // R4 / R7 one message per group
      for (int g = 0; g < 6; g++) begin
         send_a(4 * g, {26'h3ABCDEF, 6'(g * 9 + 3)});
         chk("R7 irq set", int'(irq_a[g]), 1);
      end
      for (int g = 0; g < 6; g++) drain_a(g);

      // R2 out-of-range offset
      for (int g = 0; g < 6; g++) begin rreg(0, 1, g, 0, v); tails[g] = v; end
      send_a(24, 32'h0000_0011);
      for (int g = 0; g < 6; g++) begin
         rreg(0, 1, g, 0, v); chk("R2 tail unchanged", v, tails[g]);
         rreg(0, 3, g, 0, v); chk("R2 ovf clear", v, 0);
      end

      // R6 disabled queue drop
      wreg(0, 2, 2, 0); men[2] = 0;
      send_a(8, 32'h0000_0022);
      rreg(0, 1, 2, 0, v); chk("R6 disabled tail", v, mt[2]);
      rreg(0, 3, 2, 0, v); chk("R6 disabled ovf", v, 1);
      rreg(0, 3, 4, 0, v); chk("R6 other ovf", v, 0);
      wreg(0, 2, 2, 16'h0803); men[2] = 1;

      // R5 wrap and R6 full on group 1 (head at 1)
      for (int i = 0; i < 63; i++) send_a(4, 32'(i * 5));
      rreg(0, 1, 1, 0, v); chk("R5 tail wrap", v, 0);
      rreg(0, 3, 1, 0, v); chk("R6 ovf before full drop", v, 0);
      send_a(4, 32'h0000_003F);
      rreg(0, 1, 1, 0, v); chk("R6 full tail", v, 0);
      rreg(0, 3, 1, 0, v); chk("R6 full ovf", v, 1);
      drain_a(1);

      // R9 same-cycle message and head write on group 3
      send_a(12, 32'h0000_0007);
      send_a(12, 32'h0000_0008);
      @(negedge clk);
      mv[0] = 1'b1; maddr = 16'd12; mdata = 32'h0000_0009;
      rw[0] = 1'b1; rkind = 3'd0; rgrp = 3'd3; rwd = 16'((mh[3] + 1) % 64);
      @(negedge clk);
      mv[0] = 1'b0; rw[0] = 1'b0;
      sb[3].push_back(9); mt[3] = (mt[3] + 1) % 64;
      mh[3] = (mh[3] + 1) % 64; void'(sb[3].pop_front());
      rreg(0, 0, 3, 0, v); chk("R9 head applied", v, mh[3]);
      rreg(0, 1, 3, 0, v); chk("R9 tail applied", v, mt[3]);
      drain_a(3);

      // R7 per-event bit clear keeps irq low
      wreg(0, 2, 4, 16'h0801);
      rreg(0, 1, 4, 0, t0);
      send_a(16, 32'h0000_0015);
      rreg(0, 1, 4, 0, v); chk("R7 queued without irq", v, (t0 + 1) % 64);
      chk("R7 irq gated by bit1", int'(irq_a[4]), 0);
      drain_a(4);

      // R3 4 KiB stride on second instance
      for (int g = 0; g < 4; g++) wreg(1, 2, g, 16'h0803);
      drive_msg(1, 16'h2000, 32'h0000_0021);
      rreg(1, 1, 2, 0, v); chk("R3 group2 tail", v, 1);
      drive_msg(1, 16'h0008, 32'h0000_0030);
      rreg(1, 1, 0, 0, v); chk("R3 offset 8 to group0", v, 1);
      rreg(1, 1, 2, 0, v); chk("R3 group2 unchanged", v, 1);
      rreg(1, 5, 2, 0, v); chk("R4 entry b", v, 16'h21);
      drive_msg(1, 16'h4000, 32'h0000_0001);
      for (int g = 0; g < 4; g++) begin
         rreg(1, 1, g, 0, v); chk("R2 b out of range", v, (g == 0 || g == 2) ? 1 : 0);
      end

      // R8 legacy mask
      chk("R8 masked irq", int'(irq_b), 0);
      wreg(1, 4, 0, 16'h0004);
      rreg(1, 4, 0, 0, v); chk("R8 mask readback", v, 4);
      chk("R8 irq group2", int'(irq_b[2]), 1);
      chk("R8 irq group0 masked", int'(irq_b[0]), 0);

      summary();
      $finish;
   end
endmodule